// File: doc/BRIEF.md
# Wiper Register Bank with Deferred Non-Volatile Commit

This block is the storage core of a quad digital potentiometer. It holds four 7-bit wiper positions, four stored start-up positions, three stored general-purpose bytes and an access control byte. A serial-bus engine in front of it turns bus transactions into single-cycle register accesses. It also pulses a strobe whenever the bus transaction ends. One mode bit decides whether addresses 0 to 3 reach the live wiper positions or the stored start-up positions. A write to a stored position also moves the live wiper at once.

Writes to the stored bytes are not committed straight away. The most recent one is held pending until the end-of-transaction strobe arrives. A self-timed commit then runs for a parameterised number of clock cycles. While the commit runs, a busy flag is raised and every write is refused.

After reset, all wipers sit at mid-scale, and no writes are accepted until the recall-permit input goes high. At that point each wiper is loaded from its stored start-up byte. The shutdown output combines an active-low external pin with a shutdown-enable bit in the control byte. Shutdown leaves all registers intact and still accessible.

Top module: `wiper_bank`

## Requirements
- R1: In the cycles after reset and before recall, every wiper output is 40h, nv_busy is 0, and the control byte at address 8 reads 40h.
- R2: Before recall_ok is first seen high after reset, writes are ignored. In the clock edge where it is first seen high, wiper i loads the low 7 bits of stored byte i.
- R3: The address map is as follows. Addresses 0-3 select wiper/start-up slot i. Addresses 4-6 are stored general-purpose bytes. Address 7 reads 00h and ignores writes. Address 8 is the control byte: bit 7 is the mode bit, bit 6 is the shutdown enable, bit 5 is the busy flag (read-only), and bits 4:0 read 0 and ignore writes.
- R4: With the mode bit at 1, a write to address 0-3 sets that wiper from data bits 6:0 on the next edge. A read of address 0-3 returns {0, wiper}. Addresses 4-6 read 00h and ignore writes. Stored bytes are untouched.
- R5: With the mode bit at 0, a write to address 0-3 sets the wiper from data bits 6:0 on the next edge and makes the whole byte pending. A write to 4-6 makes it pending. Reads of 0-6 return the stored (committed) byte, which does not change until a commit.
- R6: A stop_evt pulse while a write is pending raises nv_busy on the next edge. nv_busy stays high for exactly COMMIT_CYC cycles. In the edge where it falls, the stored byte takes the pending value. A stop_evt with nothing pending has no effect.
- R7: While nv_busy is 1, every write is refused, whether it targets a wiper, a stored byte, a general-purpose byte or the control byte.
- R8: Only the last stored-byte write before stop_evt is committed. Earlier pending writes in the same transaction are lost.
- R9: The shutdown output is 1 when shdn_n is 0 or control bit 6 is 0. Wiper outputs keep their values, and registers stay writable, during shutdown.
- R10: Stored bytes are not cleared by rst. A later recall loads the values committed before the reset.
- R11: Control bit 5 reads 1 while nv_busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (power-up) |
| recall_ok | input | 1 | Supply is high enough to recall stored bytes |
| reg_wr | input | 1 | Single-cycle register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| stop_evt | input | 1 | End-of-transaction strobe from the bus engine |
| shdn_n | input | 1 | External shutdown pin, active low |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| wiper_code | output | N_WIPER*WIPER_W | Wiper positions, wiper i at bits [i*WIPER_W +: WIPER_W] |
| shutdown | output | 1 | Effective shutdown |
| nv_busy | output | 1 | Non-volatile commit in progress |

## Verification
A wrong mode bit sends a read of address 0-3 to the other copy, and this shows in the same cycle as a value that differs from the one just written. A wrongly timed commit counter shows as a busy pulse whose length differs from COMMIT_CYC. A commit that lands early shows as a stored byte that reads new while busy is still high. Refusal logic that leaks lets a write during busy change a wiper output or the control byte, and this is visible on the edge after the write. Stored bytes that are lost over reset show as wrong wiper codes one cycle after recall.

// File: rtl/wb_pkg.sv
package wb_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'd8;
    localparam int CTRL_MODE = 7;
    localparam int CTRL_SDEN = 6;

    typedef enum logic [1:0] {
        T_WIPER,
        T_GP,
        T_CTRL,
        T_NONE
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] slot;
    } dec_t;

    typedef struct packed {
        logic mode_vol;
        logic sd_en;
    } ctrl_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a,
                                    input int n_wip, input int n_gp);
        dec_t d;
        d.slot = a;
        if (int'(a) < n_wip)             d.tgt = T_WIPER;
        else if (int'(a) < n_wip + n_gp) d.tgt = T_GP;
        else if (a == ADDR_CTRL)         d.tgt = T_CTRL;
        else                             d.tgt = T_NONE;
        return d;
    endfunction

    function automatic logic [DATA_W-1:0] ctrl_byte(input ctrl_t c, input logic busy);
        return {c.mode_vol, c.sd_en, busy, 5'b0};
    endfunction
endpackage

// File: rtl/wb_nv_store.sv
module wb_nv_store
    import wb_pkg::*;
#(
    parameter int N_NV       = 7,
    parameter int COMMIT_CYC = 1000000,
    localparam int SLOT_W    = (N_NV > 1) ? $clog2(N_NV) : 1,
    localparam int CNT_W     = (COMMIT_CYC > 1) ? $clog2(COMMIT_CYC) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     wr_en,
    input  logic [SLOT_W-1:0]        slot,
    input  logic [DATA_W-1:0]        wdata,
    input  logic                     stop_evt,
    output logic [N_NV*DATA_W-1:0]   nv_flat,
    output logic                     busy
);
    logic [DATA_W-1:0] nv_q [N_NV];
    logic              pend_v;
    logic [SLOT_W-1:0] pend_slot;
    logic [DATA_W-1:0] pend_data;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;

    wire commit_now = busy_q && (cnt_q == '0);

    // Stored bytes survive rst on purpose.
    always_ff @(posedge clk) begin
        if (commit_now) nv_q[pend_slot] <= pend_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_slot <= '0;
            pend_data <= '0;
            cnt_q     <= '0;
            busy_q    <= 1'b0;
        end else if (busy_q) begin
            if (commit_now) begin
                busy_q <= 1'b0;
                pend_v <= 1'b0;
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end else begin
            if (wr_en) begin
                pend_v    <= 1'b1;
                pend_slot <= slot;
                pend_data <= wdata;
            end
            if (stop_evt && pend_v) begin
                busy_q <= 1'b1;
                cnt_q  <= CNT_W'(COMMIT_CYC - 1);
            end
        end
    end

    for (genvar i = 0; i < N_NV; i++) begin : g_flat
        assign nv_flat[i*DATA_W +: DATA_W] = nv_q[i];
    end

    assign busy = busy_q;

    assert_commit_after_stop_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_q) |-> ($past(stop_evt) && $past(pend_v)));

    assert_nv_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!busy_q || cnt_q != '0) |=> $stable(nv_flat));
endmodule

// File: rtl/wb_vol_bank.sv
module wb_vol_bank
    import wb_pkg::*;
#(
    parameter int N_WIP   = 4,
    parameter int WIPER_W = 7
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     recall_ok,
    input  logic                     wr_req,
    input  logic                     busy,
    input  dec_t                     dec,
    input  logic [DATA_W-1:0]        wdata,
    input  logic [N_WIP*WIPER_W-1:0] ivr_flat,
    output logic [N_WIP*WIPER_W-1:0] wiper_flat,
    output ctrl_t                    ctrl,
    output logic                     running
);
    localparam logic [WIPER_W-1:0] MID = {1'b1, {(WIPER_W-1){1'b0}}};

    logic  run_q;
    ctrl_t ctrl_q;
    wire   accept = run_q && wr_req && !busy;

    always_ff @(posedge clk) begin
        if (rst)            run_q <= 1'b0;
        else if (recall_ok) run_q <= 1'b1;
    end

    for (genvar i = 0; i < N_WIP; i++) begin : g_wiper
        logic [WIPER_W-1:0] pos_q;
        always_ff @(posedge clk) begin
            if (rst)
                pos_q <= MID;
            else if (!run_q && recall_ok)
                pos_q <= ivr_flat[i*WIPER_W +: WIPER_W];
            else if (accept && dec.tgt == T_WIPER && int'(dec.slot) == i)
                pos_q <= wdata[WIPER_W-1:0];
        end
        assign wiper_flat[i*WIPER_W +: WIPER_W] = pos_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q.mode_vol <= 1'b0;
            ctrl_q.sd_en    <= 1'b1;
        end else if (accept && dec.tgt == T_CTRL) begin
            ctrl_q.mode_vol <= wdata[CTRL_MODE];
            ctrl_q.sd_en    <= wdata[CTRL_SDEN];
        end
    end

    assign ctrl    = ctrl_q;
    assign running = run_q;

    assert_wiper_refused_R7: assert property (@(posedge clk) disable iff (rst)
        (busy && run_q) |=> $stable(wiper_flat));

    assert_ctrl_refused_R7: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(ctrl_q));

    assert_powerup_mid_R1: assert property (@(posedge clk) disable iff (rst)
        !run_q |-> (wiper_flat == {N_WIP{MID}}));
endmodule

// File: rtl/wb_read_mux.sv
module wb_read_mux
    import wb_pkg::*;
#(
    parameter int N_WIP   = 4,
    parameter int N_NV    = 7,
    parameter int WIPER_W = 7
) (
    input  dec_t                     dec,
    input  ctrl_t                    ctrl,
    input  logic                     busy,
    input  logic [N_WIP*WIPER_W-1:0] wiper_flat,
    input  logic [N_NV*DATA_W-1:0]   nv_flat,
    output logic [DATA_W-1:0]        rdata
);
    always_comb begin
        rdata = '0;
        unique case (dec.tgt)
            T_WIPER: rdata = ctrl.mode_vol
                           ? DATA_W'(wiper_flat[int'(dec.slot)*WIPER_W +: WIPER_W])
                           : nv_flat[int'(dec.slot)*DATA_W +: DATA_W];
            T_GP:    rdata = ctrl.mode_vol ? '0 : nv_flat[int'(dec.slot)*DATA_W +: DATA_W];
            T_CTRL:  rdata = ctrl_byte(ctrl, busy);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/wiper_bank.sv
module wiper_bank
    import wb_pkg::*;
#(
    parameter int N_WIPER    = 4,
    parameter int N_GP       = 3,
    parameter int WIPER_W    = 7,
    parameter int COMMIT_CYC = 1000000
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       recall_ok,
    input  logic                       reg_wr,
    input  logic [3:0]                 reg_addr,
    input  logic [7:0]                 reg_wdata,
    input  logic                       stop_evt,
    input  logic                       shdn_n,
    output logic [7:0]                 reg_rdata,
    output logic [N_WIPER*WIPER_W-1:0] wiper_code,
    output logic                       shutdown,
    output logic                       nv_busy
);
    localparam int N_NV   = N_WIPER + N_GP;
    localparam int SLOT_W = (N_NV > 1) ? $clog2(N_NV) : 1;

    dec_t  dec;
    ctrl_t ctrl;
    logic  running;
    logic  busy;
    logic  nv_wr;
    logic [N_NV*DATA_W-1:0]      nv_flat;
    logic [N_WIPER*WIPER_W-1:0]  ivr_flat;

    assign dec   = decode(reg_addr, N_WIPER, N_GP);
    assign nv_wr = running && reg_wr && !busy && !ctrl.mode_vol &&
                   (dec.tgt == T_WIPER || dec.tgt == T_GP);

    for (genvar i = 0; i < N_WIPER; i++) begin : g_ivr
        assign ivr_flat[i*WIPER_W +: WIPER_W] = nv_flat[i*DATA_W +: WIPER_W];
    end

    wb_nv_store #(.N_NV(N_NV), .COMMIT_CYC(COMMIT_CYC)) u_nv (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (nv_wr),
        .slot     (reg_addr[SLOT_W-1:0]),
        .wdata    (reg_wdata),
        .stop_evt (stop_evt),
        .nv_flat  (nv_flat),
        .busy     (busy)
    );

    wb_vol_bank #(.N_WIP(N_WIPER), .WIPER_W(WIPER_W)) u_vol (
        .clk        (clk),
        .rst        (rst),
        .recall_ok  (recall_ok),
        .wr_req     (reg_wr),
        .busy       (busy),
        .dec        (dec),
        .wdata      (reg_wdata),
        .ivr_flat   (ivr_flat),
        .wiper_flat (wiper_code),
        .ctrl       (ctrl),
        .running    (running)
    );

    wb_read_mux #(.N_WIP(N_WIPER), .N_NV(N_NV), .WIPER_W(WIPER_W)) u_rd (
        .dec        (dec),
        .ctrl       (ctrl),
        .busy       (busy),
        .wiper_flat (wiper_code),
        .nv_flat    (nv_flat),
        .rdata      (reg_rdata)
    );

    assign shutdown = !(shdn_n && ctrl.sd_en);
    assign nv_busy  = busy;
endmodule

// File: tb/wiper_bank_tb.sv
module wiper_bank_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COMMIT     = 8;
    localparam int NW = 4;
    localparam int WW = 7;

    localparam logic [1:0] OP_W = 2'd0, OP_R = 2'd1, OP_S = 2'd2, OP_P = 2'd3;

    typedef struct packed {
        logic [1:0] op;
        logic [3:0] addr;
        logic [7:0] data;
        logic [3:0] req;
    } vec_t;

    // data field: write value, or expected value for OP_R / OP_P
    localparam int NV = 45;
    localparam vec_t VEC [NV] = '{
        '{OP_W, 4'd8, 8'h40, 4'd3},
        '{OP_W, 4'd0, 8'h15, 4'd5},
        '{OP_P, 4'd0, 8'h15, 4'd5},   // R5 wiper moves at once
        '{OP_S, 4'd0, 8'h00, 4'd6},
        '{OP_R, 4'd0, 8'h15, 4'd6},   // R6 committed
        '{OP_W, 4'd1, 8'h8A, 4'd5},
        '{OP_S, 4'd0, 8'h00, 4'd6},
        '{OP_R, 4'd1, 8'h8A, 4'd5},   // R5 full byte stored
        '{OP_P, 4'd1, 8'h0A, 4'd5},   // R5 wiper takes bits 6:0
        '{OP_W, 4'd2, 8'h33, 4'd5},
        '{OP_S, 4'd0, 8'h00, 4'd6},
        '{OP_W, 4'd3, 8'h7F, 4'd5},
        '{OP_S, 4'd0, 8'h00, 4'd6},
        '{OP_W, 4'd4, 8'hA5, 4'd3},
        '{OP_S, 4'd0, 8'h00, 4'd6},
        '{OP_R, 4'd4, 8'hA5, 4'd3},   // R3 general-purpose byte
        '{OP_W, 4'd5, 8'h5A, 4'd3},
        '{OP_S, 4'd0, 8'h00, 4'd6},
        '{OP_W, 4'd6, 8'hC3, 4'd3},
        '{OP_S, 4'd0, 8'h00, 4'd6},
        '{OP_R, 4'd6, 8'hC3, 4'd3},
        '{OP_W, 4'd7, 8'hFF, 4'd3},
        '{OP_R, 4'd7, 8'h00, 4'd3},   // R3 hole reads 0
        '{OP_W, 4'd8, 8'hFF, 4'd3},
        '{OP_R, 4'd8, 8'hC0, 4'd3},   // R3 bits 5:0 not writable
        '{OP_W, 4'd0, 8'h01, 4'd4},
        '{OP_R, 4'd0, 8'h01, 4'd4},   // R4 volatile read
        '{OP_P, 4'd0, 8'h01, 4'd4},
        '{OP_R, 4'd4, 8'h00, 4'd4},   // R4 GP hidden
        '{OP_W, 4'd4, 8'h11, 4'd4},
        '{OP_W, 4'd8, 8'h40, 4'd4},
        '{OP_R, 4'd4, 8'hA5, 4'd4},   // R4 GP write ignored
        '{OP_R, 4'd0, 8'h15, 4'd4},   // R4 stored byte untouched
        '{OP_W, 4'd0, 8'h22, 4'd5},
        '{OP_R, 4'd0, 8'h15, 4'd5},   // R5 old until commit
        '{OP_S, 4'd0, 8'h00, 4'd6},
        '{OP_R, 4'd0, 8'h22, 4'd6},
        '{OP_W, 4'd1, 8'h10, 4'd8},
        '{OP_W, 4'd2, 8'h20, 4'd8},
        '{OP_S, 4'd0, 8'h00, 4'd8},
        '{OP_R, 4'd1, 8'h8A, 4'd8},   // R8 earlier byte lost
        '{OP_R, 4'd2, 8'h20, 4'd8},   // R8 last byte kept
        '{OP_S, 4'd0, 8'h00, 4'd6},   // R6 stop with nothing pending
        '{OP_R, 4'd8, 8'h40, 4'd6},
        '{OP_R, 4'd5, 8'h5A, 4'd3}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic recall_ok = 1'b0;
    logic reg_wr = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic stop_evt = 1'b0;
    logic shdn_n = 1'b1;
    logic [7:0] reg_rdata;
    logic [NW*WW-1:0] wiper_code;
    logic shutdown;
    logic nv_busy;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wiper_bank #(.COMMIT_CYC(COMMIT)) u_dut (
        .clk(clk), .rst(rst), .recall_ok(recall_ok), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .stop_evt(stop_evt),
        .shdn_n(shdn_n), .reg_rdata(reg_rdata), .wiper_code(wiper_code),
        .shutdown(shutdown), .nv_busy(nv_busy)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge.
    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic stop_pulse();
        stop_evt = 1'b1;
        @(negedge clk);
        stop_evt = 1'b0;
    endtask

    task automatic wait_idle();
        while (nv_busy) @(negedge clk);
    endtask

    task automatic rd(input string req, input logic [3:0] a, input logic [7:0] e);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, e);
    endtask

    function automatic logic [6:0] wpos(input int i);
        return wiper_code[i*WW +: WW];
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        for (int i = 0; i < NW; i++) chk("R1 wiper mid", wpos(i), 7'h40);
        chk("R1 busy", nv_busy, 1'b0);
        chk("R1 shutdown", shutdown, 1'b0);
        rd("R1 ctrl", 4'd8, 8'h40);
        // R2 writes ignored before recall
        wr(4'd8, 8'h80);
        rd("R2 pre-recall write", 4'd8, 8'h40);
        recall_ok = 1'b1;
        @(negedge clk);

        for (int k = 0; k < NV; k++) begin
            case (VEC[k].op)
                OP_W: wr(VEC[k].addr, VEC[k].data);
                OP_S: begin stop_pulse(); wait_idle(); end
                OP_R: begin
                    reg_addr = VEC[k].addr; #1;
                    checks++;
                    if (reg_rdata !== VEC[k].data) begin
                        errors++;
                        $display("FAIL R%0d vec %0d read: actual %0h expected %0h",
                                 VEC[k].req, k, reg_rdata, VEC[k].data);
                    end
                end
                default: begin
                    checks++;
                    if ({1'b0, wpos(int'(VEC[k].addr))} !== VEC[k].data) begin
                        errors++;
                        $display("FAIL R%0d vec %0d wiper: actual %0h expected %0h",
                                 VEC[k].req, k, wpos(int'(VEC[k].addr)), VEC[k].data);
                    end
                end
            endcase
            if (VEC[k].op != OP_W && VEC[k].op != OP_S) @(negedge clk);
        end

        // R6 / R11 busy length and flag
        wr(4'd3, 8'h44);
        reg_addr = 4'd8;
        stop_pulse();
        #1;
        chk("R11 ctrl busy bit", reg_rdata, 8'h60);
        begin
            int n = 0;
            while (nv_busy) begin n++; @(negedge clk); end
            chk("R6 busy cycles", n, COMMIT);
        end
        rd("R6 commit value", 4'd3, 8'h44);
        @(negedge clk);

        // R7 writes refused while busy
        wr(4'd0, 8'h55);
        stop_pulse();
        wr(4'd8, 8'h80);
        wr(4'd1, 8'h7E);
        wr(4'd5, 8'h00);
        wr(4'd3, 8'h11);
        chk("R7 still busy", nv_busy, 1'b1);
        wait_idle();
        rd("R7 ctrl kept", 4'd8, 8'h40);
        chk("R7 wiper1 kept", wpos(1), 7'h10);
        chk("R7 wiper3 kept", wpos(3), 7'h44);
        rd("R7 gp kept", 4'd5, 8'h5A);
        rd("R7 stored3 kept", 4'd3, 8'h44);
        rd("R7 stored0 committed", 4'd0, 8'h55);
        @(negedge clk);

        // R9 shutdown
        shdn_n = 1'b0; #1;
        chk("R9 pin shutdown", shutdown, 1'b1);
        chk("R9 wiper kept", wpos(0), 7'h55);
        @(negedge clk);
        wr(4'd8, 8'hC0);
        rd("R9 writable in shutdown", 4'd8, 8'hC0);
        @(negedge clk);
        wr(4'd0, 8'h30);
        chk("R9 wiper written", wpos(0), 7'h30);
        shdn_n = 1'b1; #1;
        chk("R9 pin released", shutdown, 1'b0);
        @(negedge clk);
        wr(4'd8, 8'h00); #1;
        chk("R9 bit shutdown", shutdown, 1'b1);
        chk("R9 wiper kept bit", wpos(0), 7'h30);
        @(negedge clk);
        wr(4'd8, 8'h40); #1;
        chk("R9 bit released", shutdown, 1'b0);
        @(negedge clk);

        // R10 stored bytes survive reset, R2 recall
        rst = 1'b1; recall_ok = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 mid after reset", wpos(0), 7'h40);
        rd("R1 ctrl after reset", 4'd8, 8'h40);
        @(negedge clk);
        recall_ok = 1'b1;
        @(negedge clk);
        chk("R10 recall 0", wpos(0), 7'h55);
        chk("R10 recall 1", wpos(1), 7'h0A);
        chk("R2 recall 2", wpos(2), 7'h20);
        chk("R2 recall 3", wpos(3), 7'h44);
        rd("R10 gp kept", 4'd4, 8'hA5);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule